// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic unit of a small accumulator processor. It holds the processor's four condition flags (zero, subtract, half-carry, carry). Each cycle in which an operation is issued, it takes an operation code, the accumulator value, one operand and a bit index. It computes a result and a new flag set from these inputs and from the carry flag it already holds. The instruction decoder drives the operation; the register file reads the result back.

The operations are increment, decrement, add, add with carry, subtract, subtract with borrow, exclusive OR, compare, rotate of the accumulator left through carry, and single-bit test. Each one has its own rule for the flags: a flag is either forced, computed or held. Compare and bit test change only the flags. They raise no write strobe, and the result output keeps its previous value. Result, write strobe and flags are all registered, so the effect of an operation appears at the outputs one clock after it is issued.

Top module: `accum_alu`

## Requirements
- R1: While reset is low and after it is released, `result_out` is 0, `wr_en_out` is 0 and `flags_out` is 0 until the first operation is issued.
- R2: Code 0 (increment) writes `opnd_in`+1 modulo 256. It sets Z when that value is 0, clears N, sets H when the low nibble of the operand was 0xF, and holds C.
- R3: Code 1 (decrement) writes `opnd_in`-1 modulo 256. It sets Z when that value is 0 and clears Z otherwise, sets N, sets H when the low nibble of the operand was 0, and holds C.
- R4: Code 2 (add) and code 3 (add with carry) write A+B, plus the held C for code 3, modulo 256. They set Z from the result, clear N, set H on a carry out of bit 3 and set C on a carry out of bit 7.
- R5: Code 4 (subtract) and code 5 (subtract with borrow) write A-B, minus the held C for code 5, modulo 256. They set Z from the result and set N. H is set when the subtrahend's low nibble (plus C for code 5) exceeds A's low nibble. C is set when B (plus C for code 5) exceeds A.
- R6: Code 6 (exclusive OR) writes A^B, sets Z from the result and clears N, H and C.
- R7: Code 7 (compare) applies the subtract flag rule to A-B without writing: `wr_en_out` stays 0 and `result_out` keeps its value. Z is set when A equals B and C is set when B is greater than A.
- R8: Code 8 (rotate) writes A shifted left by one with the old C in bit 0. Old bit 7 of A becomes the new C, and Z, N and H are cleared.
- R9: Code 9 (bit test) sets Z when bit `bit_sel` of `opnd_in` is 0 and clears it otherwise. It clears N, sets H and holds C, and it does not write.
- R10: `flags_out` carries Z, N, H and C in bits 7, 6, 5 and 4, and bits 3..0 always read 0. The outputs for an operation issued at one clock edge appear after that edge.
- R11: A cycle with `op_valid` low, or with a code from 10 to 15, changes neither flags nor result and leaves `wr_en_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_code | input | 4 | Operation code (0..9 defined) |
| bit_sel | input | 3 | Bit index for bit test |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand / increment-decrement source |
| result_out | output | 8 | Registered result |
| wr_en_out | output | 1 | Result was written by the last operation |
| flags_out | output | 8 | Z,N,H,C in bits 7..4, low nibble zero |

## Verification
The bench builds the block with its default 8-bit data width, which places the half-carry boundary between bits 3 and 4 and the carry boundary at bit 7. At that width the directed cases can reach every wrap and nibble edge exactly: 0xFF to 0x00, 0x0F to 0x10, and 0x00 to 0xFF. The random phase then reaches all ten operations, and their carry-in dependence, under a carry flag that earlier operations left set or clear.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  typedef enum logic [3:0] {
    OP_INC = 4'd0,
    OP_DEC = 4'd1,
    OP_ADD = 4'd2,
    OP_ADC = 4'd3,
    OP_SUB = 4'd4,
    OP_SBC = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_RLC = 4'd8,
    OP_TST = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;

  localparam int FLAG_BYTE_W = 8;
  localparam int FLAG_PAD_W  = FLAG_BYTE_W - $bits(alu_flags_t);

endpackage

// File: rtl/accum_alu_core.sv
module accum_alu_core
  import accum_alu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int BSW = $clog2(DW)
) (
  input  alu_op_e          op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic [BSW-1:0]   bsel,
  input  alu_flags_t       flags_in,
  output logic [DW-1:0]    res,
  output alu_flags_t       flags_nx,
  output logic             wb,
  output logic             upd
);

  localparam int HB = DW / 2;

  // returns {half_carry, carry, sum}
  function automatic logic [DW+1:0] add_f(input logic [DW-1:0] x,
                                          input logic [DW-1:0] y,
                                          input logic          ci);
    logic [DW:0] full;
    logic [HB:0] low;
    full = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    low  = {1'b0, x[HB-1:0]} + {1'b0, y[HB-1:0]} + {{HB{1'b0}}, ci};
    return {low[HB], full};
  endfunction

  // returns {half_borrow, borrow, difference}
  function automatic logic [DW+1:0] sub_f(input logic [DW-1:0] x,
                                          input logic [DW-1:0] y,
                                          input logic          ci);
    logic [DW:0] full;
    logic [HB:0] low;
    full = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, ci};
    low  = {1'b0, x[HB-1:0]} - {1'b0, y[HB-1:0]} - {{HB{1'b0}}, ci};
    return {low[HB], full};
  endfunction

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW+1:0] ext;

  always_comb begin
    res      = a;
    flags_nx = flags_in;
    wb       = 1'b0;
    upd      = 1'b1;
    ext      = '0;
    unique case (op)
      OP_INC: begin
        ext        = add_f(b, ONE, 1'b0);
        res        = ext[DW-1:0];
        flags_nx.z = ~|ext[DW-1:0];
        flags_nx.n = 1'b0;
        flags_nx.h = ext[DW+1];
        wb         = 1'b1;
      end
      OP_DEC: begin
        ext        = sub_f(b, ONE, 1'b0);
        res        = ext[DW-1:0];
        flags_nx.z = ~|ext[DW-1:0];
        flags_nx.n = 1'b1;
        flags_nx.h = ext[DW+1];
        wb         = 1'b1;
      end
      OP_ADD, OP_ADC: begin
        ext        = add_f(a, b, (op == OP_ADC) & flags_in.c);
        res        = ext[DW-1:0];
        flags_nx.z = ~|ext[DW-1:0];
        flags_nx.n = 1'b0;
        flags_nx.h = ext[DW+1];
        flags_nx.c = ext[DW];
        wb         = 1'b1;
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        ext        = sub_f(a, b, (op == OP_SBC) & flags_in.c);
        flags_nx.z = ~|ext[DW-1:0];
        flags_nx.n = 1'b1;
        flags_nx.h = ext[DW+1];
        flags_nx.c = ext[DW];
        if (op != OP_CMP) begin
          res = ext[DW-1:0];
          wb  = 1'b1;
        end
      end
      OP_XOR: begin
        res        = a ^ b;
        flags_nx.z = ~|(a ^ b);
        flags_nx.n = 1'b0;
        flags_nx.h = 1'b0;
        flags_nx.c = 1'b0;
        wb         = 1'b1;
      end
      OP_RLC: begin
        res        = {a[DW-2:0], flags_in.c};
        flags_nx.z = 1'b0;
        flags_nx.n = 1'b0;
        flags_nx.h = 1'b0;
        flags_nx.c = a[DW-1];
        wb         = 1'b1;
      end
      OP_TST: begin
        flags_nx.z = ~b[bsel];
        flags_nx.n = 1'b0;
        flags_nx.h = 1'b1;
      end
      default: upd = 1'b0;
    endcase
  end

endmodule

// File: rtl/accum_alu_state.sv
module accum_alu_state
  import accum_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          upd,
  input  logic          wb,
  input  logic [DW-1:0] res_nx,
  input  alu_flags_t    flags_nx,
  output logic [DW-1:0] res_q,
  output logic          wb_q,
  output alu_flags_t    flags_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      wb_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      wb_q <= fire & wb;
      if (fire & upd) flags_q <= flags_nx;
      if (fire & wb)  res_q   <= res_nx;
    end
  end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
#(
  parameter int DW  = 8,
  parameter int BSW = $clog2(DW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [3:0]             op_code,
  input  logic [BSW-1:0]         bit_sel,
  input  logic [DW-1:0]          acc_in,
  input  logic [DW-1:0]          opnd_in,
  output logic [DW-1:0]          result_out,
  output logic                   wr_en_out,
  output logic [FLAG_BYTE_W-1:0] flags_out
);

  alu_flags_t    flags_cur;
  alu_flags_t    flags_nx;
  logic [DW-1:0] res_nx;
  logic          wb_evt;
  logic          upd_evt;

  accum_alu_core #(.DW(DW), .BSW(BSW)) u_core (
    .op       (alu_op_e'(op_code)),
    .a        (acc_in),
    .b        (opnd_in),
    .bsel     (bit_sel),
    .flags_in (flags_cur),
    .res      (res_nx),
    .flags_nx (flags_nx),
    .wb       (wb_evt),
    .upd      (upd_evt)
  );

  accum_alu_state #(.DW(DW)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (op_valid),
    .upd      (upd_evt),
    .wb       (wb_evt),
    .res_nx   (res_nx),
    .flags_nx (flags_nx),
    .res_q    (result_out),
    .wb_q     (wr_en_out),
    .flags_q  (flags_cur)
  );

  assign flags_out = {flags_cur, {FLAG_PAD_W{1'b0}}};

endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk #(
  parameter int DW  = 8,
  parameter int BSW = $clog2(DW)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [3:0]     op_code,
  input logic [BSW-1:0] bit_sel,
  input logic [DW-1:0]  acc_in,
  input logic [DW-1:0]  opnd_in,
  input logic [DW-1:0]  result_out,
  input logic           wr_en_out,
  input logic [7:0]     flags_out
);

  // R10
  nibble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_out[3:0] == 4'd0);

  // R2
  inc_hold_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd0) |=>
      (wr_en_out && !flags_out[6] && flags_out[4] == $past(flags_out[4])));

  // R3
  dec_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd1) |=>
      (wr_en_out && flags_out[6] && flags_out[4] == $past(flags_out[4])
       && flags_out[7] == (result_out == '0)));

  // R6
  xor_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd6) |=>
      (flags_out[6:4] == 3'b000 && flags_out[7] == (result_out == '0)));

  // R7
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd7) |=>
      (!wr_en_out && flags_out[6] && $stable(result_out)));

  // R8
  rot_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd8) |=>
      (result_out[0] == $past(flags_out[4]) && flags_out[4] == $past(acc_in[DW-1])
       && flags_out[7:5] == 3'b000));

  // R9
  bit_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd9) |=>
      (flags_out[7] == !$past(opnd_in[bit_sel]) && flags_out[6:5] == 2'b01
       && flags_out[4] == $past(flags_out[4]) && !wr_en_out));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code > 4'd9) |=>
      ($stable(flags_out) && $stable(result_out) && !wr_en_out));

endmodule

bind accum_alu accum_alu_chk #(.DW(DW), .BSW(BSW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .bit_sel    (bit_sel),
  .acc_in     (acc_in),
  .opnd_in    (opnd_in),
  .result_out (result_out),
  .wr_en_out  (wr_en_out),
  .flags_out  (flags_out)
);

// File: tb/accum_alu_tb.sv
`timescale 1ns/1ps
module accum_alu_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [2:0] bit_sel = 3'd0;
  logic [7:0] acc_in = 8'd0;
  logic [7:0] opnd_in = 8'd0;
  logic [7:0] result_out;
  logic       wr_en_out;
  logic [7:0] flags_out;

  always #2 clk = ~clk;

  accum_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .bit_sel(bit_sel), .acc_in(acc_in), .opnd_in(opnd_in),
    .result_out(result_out), .wr_en_out(wr_en_out), .flags_out(flags_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int e_res = 0;
  int e_wb = 0;
  int e_z = 0, e_n = 0, e_h = 0, e_c = 0;
  string cur_tag = "R1";

  function automatic string tag_of(input bit v, input int op);
    if (!v || op > 9) return "R11";
    case (op)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic compare();
    int ef;
    ef = (e_z << 7) | (e_n << 6) | (e_h << 5) | (e_c << 4);
    checks++;
    if (result_out !== 8'(e_res) || wr_en_out !== 1'(e_wb) || flags_out !== 8'(ef)) begin
      errors++;
      $display("FAIL %s: res=%02h wr=%0d flags=%02h expected res=%02h wr=%0d flags=%02h",
               cur_tag, result_out, wr_en_out, flags_out, e_res, e_wb, ef);
    end
    checks++;
    if (flags_out[3:0] !== 4'd0) begin
      errors++;
      $display("FAIL R10: flag low nibble=%h expected 0", flags_out[3:0]);
    end
  endtask

  task automatic model(input bit v, input int op, input int a, input int b, input int n);
    int r, ci;
    e_wb = 0;
    if (!v || op > 9) return;
    ci = e_c;
    case (op)
      0: begin r = (b + 1) % 256; e_z = (r == 0); e_n = 0; e_h = ((b % 16) == 15); e_res = r; e_wb = 1; end
      1: begin r = (b + 255) % 256; e_z = (r == 0); e_n = 1; e_h = ((b % 16) == 0); e_res = r; e_wb = 1; end
      2, 3: begin
        if (op == 2) ci = 0;
        r = a + b + ci;
        e_h = ((a % 16) + (b % 16) + ci) > 15;
        e_c = r > 255; r = r % 256;
        e_z = (r == 0); e_n = 0; e_res = r; e_wb = 1;
      end
      4, 5, 7: begin
        if (op != 5) ci = 0;
        r = (a - b - ci + 512) % 256;
        e_h = (a % 16) < ((b % 16) + ci);
        e_c = (b + ci) > a;
        e_z = (r == 0); e_n = 1;
        if (op != 7) begin e_res = r; e_wb = 1; end
      end
      6: begin r = a ^ b; e_z = (r == 0); e_n = 0; e_h = 0; e_c = 0; e_res = r; e_wb = 1; end
      8: begin r = ((a * 2) % 256) + ci; e_c = a / 128; e_z = 0; e_n = 0; e_h = 0; e_res = r; e_wb = 1; end
      default: begin e_z = ((b >> n) & 1) == 0; e_n = 0; e_h = 1; end
    endcase
  endtask

  // one cycle: check what the previous edge produced, then issue a new operation
  task automatic step(input bit v, input int op, input int a, input int b, input int n);
    @(negedge clk);
    compare();
    op_valid = v; op_code = 4'(op); acc_in = 8'(a); opnd_in = 8'(b); bit_sel = 3'(n);
    cur_tag = tag_of(v, op);
    model(v, op, a, b, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    compare();                       // R1 in reset
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_tag = "R1";
    compare();                       // R1 after release
    // R2 increment corners
    step(1, 0, 0, 8'hFF, 0);
    step(1, 0, 0, 8'h0F, 0);
    step(1, 0, 0, 8'h41, 0);
    // R3 decrement corners
    step(1, 1, 0, 8'h01, 0);
    step(1, 1, 0, 8'h10, 0);
    step(1, 1, 0, 8'h00, 0);
    // R4 add / add with carry
    step(1, 2, 8'h0F, 8'h01, 0);
    step(1, 2, 8'hF0, 8'h10, 0);
    step(1, 3, 8'h7F, 8'h00, 0);
    step(1, 3, 8'hFE, 8'h01, 0);
    // R5 subtract / with borrow
    step(1, 4, 8'h10, 8'h01, 0);
    step(1, 4, 8'h22, 8'h22, 0);
    step(1, 4, 8'h00, 8'h01, 0);
    step(1, 5, 8'h05, 8'h05, 0);
    step(1, 5, 8'h30, 8'h0F, 0);
    // R6 xor
    step(1, 6, 8'hA5, 8'hA5, 0);
    step(1, 6, 8'hA5, 8'h5A, 0);
    // R7 compare
    step(1, 7, 8'h10, 8'h20, 0);
    step(1, 7, 8'h33, 8'h33, 0);
    step(1, 7, 8'h40, 8'h01, 0);
    // R8 rotate through carry
    step(1, 8, 8'h80, 0, 0);
    step(1, 8, 8'h01, 0, 0);
    step(1, 8, 8'h00, 0, 0);
    // R9 bit test every index
    for (int i = 0; i < 8; i++) step(1, 9, 0, 8'hA5, i);
    // R11 idle and undefined codes
    step(0, 2, 8'hFF, 8'hFF, 0);
    for (int k = 10; k < 16; k++) step(1, k, 8'hFF, 8'h01, 0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom_range(0, 7) != 0), $urandom_range(0, 15), $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 7));
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule